// File: doc/BRIEF.md
# Prioritized Pending Interrupt Arbiter

This block keeps one pending flag per asynchronous interrupt source of a processor core and, in every cycle, offers at most one of them to the exception entry logic. The choice follows a fixed priority. Each source also has its own masking rule, built from the machine-state enable bits and from partition control bits. Once a source is offered, its flag is either dropped or kept, according to that source's delivery rule. A hard-interrupt request output stays high for as long as any flag is pending.

Most sources raise their flag with a one-cycle set pulse. The external and critical-external sources are levels: their flags copy the input level each cycle. A power-save entry strobe drops any pending hypervisor decrementer. It also forces external-enable on until the next delivery, so that a wakeup source can get through. The offered cause comes from the registered flags and the current enable inputs in the same cycle.

Top module: `irq_pend_arbiter`

## Requirements
- R1: Source index, which is also the value on `take_cause` and the bit of `take_onehot`, runs from highest to lowest priority: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable-interval timer, 9 decrementer, 10 doorbell, 11 performance monitor, 12 thermal. The pending, eligible source with the lowest index is offered.
- R2: Reset (0) and machine check (1) are eligible whenever pending, whatever the enables. Delivery clears their flags.
- R3: Hypervisor decrementer (2) is eligible only when `part_hdec_en` is 1 and either effective external-enable is 1 or `hv_mode` is 0. Delivery clears its flag.
- R4: External (3) is eligible when effective external-enable is 1, or when `hv_present` is 1, `hv_mode` is 0 and `part_ext_sel` is 0. Its flag equals `ext_lvl` from the previous cycle and is not cleared by delivery.
- R5: Critical external (4) is eligible only when `ce_bit` is 1. Its flag equals `crit_lvl` from the previous cycle and is not cleared by delivery.
- R6: Sources 5 to 12 are eligible only when effective external-enable is 1. Delivery clears each of them, except the decrementer (9).
- R7: Delivery clears the decrementer flag only when `dec_clear_cfg` is 1. Otherwise the flag stays set and the decrementer is offered again.
- R8: A `pwr_save_enter` pulse clears the hypervisor decrementer flag, including a set pulse in the same cycle. From the next cycle, effective external-enable is 1 until the cycle after the next delivery in which no new `pwr_save_enter` pulse arrives.
- R9: A set pulse in the same cycle as the delivery that would clear the same source leaves its flag set.
- R10: `hard_req` is 1 exactly when at least one flag is pending after the last clock edge.
- R11: `src_set` bits 3 and 4 have no effect, because those flags follow their level inputs.
- R12: After reset no flag is pending, `take_valid` and `hard_req` are 0, and external-enable is not forced.
- R13: `take_onehot` has the bit of `take_cause` set when `take_valid` is 1, and is all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | 13 | Set pulse per source, indexed as in R1 |
| ext_lvl | input | 1 | External interrupt level |
| crit_lvl | input | 1 | Critical external interrupt level |
| ee_bit | input | 1 | External-enable from machine state |
| ce_bit | input | 1 | Critical-enable from machine state |
| hv_mode | input | 1 | Core is in hypervisor state |
| part_ext_sel | input | 1 | Partition external-select bit |
| part_hdec_en | input | 1 | Partition hypervisor-decrementer enable |
| hv_present | input | 1 | Core implements hypervisor mode |
| dec_clear_cfg | input | 1 | Decrementer clears on delivery |
| pwr_save_enter | input | 1 | Power-save entry strobe |
| take_valid | output | 1 | A source is offered this cycle |
| take_cause | output | 4 | Index of the offered source |
| take_onehot | output | 13 | One-hot form of the offered source |
| hard_req | output | 1 | Any flag pending |

## Verification
A flag that is wrongly cleared or wrongly kept shows on `hard_req` in the cycle after the edge where it happened. It shows on `take_cause` as soon as that source is the highest eligible one. A wrong forced-enable state appears only when an enable-gated source is pending while `ee_bit` is low. For that reason the random stimulus keeps `ee_bit` low often and mixes in power-save pulses. Because the outputs come from the registered flags and the current enables, the reference model is compared with every output once per cycle.

// File: rtl/irqarb_pkg.sv
// Shared constants and types for the pending interrupt arbiter.
// Assumes the source ordering below is also the priority ordering.
package irqarb_pkg;
    localparam int NSRC = 13;
    localparam int CW   = $clog2(NSRC);

    localparam int S_RST   = 0;
    localparam int S_MCK   = 1;
    localparam int S_HDEC  = 2;
    localparam int S_EXT   = 3;
    localparam int S_CEXT  = 4;
    localparam int S_WDT   = 5;
    localparam int S_CDB   = 6;
    localparam int S_FIT   = 7;
    localparam int S_PIT   = 8;
    localparam int S_DEC   = 9;
    localparam int S_DB    = 10;
    localparam int S_PERF  = 11;
    localparam int S_THERM = 12;

    // Sources cleared on delivery regardless of configuration
    localparam logic [NSRC-1:0] CLR_FIXED = 13'b1_1101_1110_0111;

    typedef struct packed {
        logic ee;       // effective external-enable
        logic ce;
        logic hv;
        logic ext_sel;
        logic hdec_en;
        logic has_hv;
    } gate_ctl_t;
endpackage

// File: rtl/irqarb_pend.sv
// Pending flag register plus the forced external-enable bit.
// Assumes clr_mask carries only the currently delivered source.
module irqarb_pend
    import irqarb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_pulse,
    input  logic            ext_lvl,
    input  logic            crit_lvl,
    input  logic [NSRC-1:0] clr_mask,
    input  logic            pwr_save,
    input  logic            dlv_any,
    output logic [NSRC-1:0] pend_q,
    output logic            force_q
);
    logic [NSRC-1:0] pend_d;

    // Next value of each flag, chosen per source kind
    for (genvar i = 0; i < NSRC; i++) begin : g_next
        if (i == S_EXT) begin : g_ext
            assign pend_d[i] = ext_lvl;
        end else if (i == S_CEXT) begin : g_cext
            assign pend_d[i] = crit_lvl;
        end else if (i == S_HDEC) begin : g_hdec
            assign pend_d[i] = ~pwr_save & (set_pulse[i] | (pend_q[i] & ~clr_mask[i]));
        end else begin : g_pulse
            assign pend_d[i] = set_pulse[i] | (pend_q[i] & ~clr_mask[i]);
        end
    end

    // State update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            force_q <= 1'b0;
        end else begin
            pend_q  <= pend_d;
            force_q <= pwr_save | (force_q & ~dlv_any);
        end
    end
endmodule

// File: rtl/irqarb_gate.sv
// Applies the per-source masking rules to the pending flags.
// Assumes ctl.ee already includes any forced enable.
module irqarb_gate
    import irqarb_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  gate_ctl_t       ctl,
    output logic [NSRC-1:0] elig
);
    logic ext_bypass;

    // Guest-state path that lets externals ignore external-enable
    assign ext_bypass = ctl.has_hv & ~ctl.hv & ~ctl.ext_sel;

    for (genvar i = 0; i < NSRC; i++) begin : g_mask
        if (i == S_RST || i == S_MCK) begin : g_nmi
            assign elig[i] = pend[i];
        end else if (i == S_HDEC) begin : g_hdec
            assign elig[i] = pend[i] & ctl.hdec_en & (ctl.ee | ~ctl.hv);
        end else if (i == S_EXT) begin : g_ext
            assign elig[i] = pend[i] & (ctl.ee | ext_bypass);
        end else if (i == S_CEXT) begin : g_cext
            assign elig[i] = pend[i] & ctl.ce;
        end else begin : g_ee
            assign elig[i] = pend[i] & ctl.ee;
        end
    end
endmodule

// File: rtl/irqarb_pick.sv
// Fixed-priority picker: lowest index wins; gives one-hot and encoded forms.
// Assumes nothing about how many requests are active.
module irqarb_pick
    import irqarb_pkg::*;
(
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] grant,
    output logic [CW-1:0]   cause,
    output logic            any
);
    logic [NSRC:0] blocked;

    assign blocked[0] = 1'b0;
    // Ripple chain marking sources shadowed by a higher priority one
    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign grant[i]     = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end
    assign any = blocked[NSRC];

    // Encode the granted index
    always_comb begin
        cause = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) cause = cause | CW'(i);
        end
    end
endmodule

// File: rtl/irq_pend_arbiter.sv
// Top level: pending flags, masking and priority pick for async interrupts.
// Assumes the consumer takes the offered cause in the cycle it is shown.
module irq_pend_arbiter
    import irqarb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_set,
    input  logic            ext_lvl,
    input  logic            crit_lvl,
    input  logic            ee_bit,
    input  logic            ce_bit,
    input  logic            hv_mode,
    input  logic            part_ext_sel,
    input  logic            part_hdec_en,
    input  logic            hv_present,
    input  logic            dec_clear_cfg,
    input  logic            pwr_save_enter,
    output logic            take_valid,
    output logic [CW-1:0]   take_cause,
    output logic [NSRC-1:0] take_onehot,
    output logic            hard_req
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] clr_sel;
    logic            force_q;
    gate_ctl_t       ctl;

    // Which delivered sources drop their flag
    always_comb begin
        clr_sel        = CLR_FIXED;
        clr_sel[S_DEC] = dec_clear_cfg;
    end
    assign clr_mask = take_onehot & clr_sel;

    // Gate controls with the forced enable folded in
    always_comb begin
        ctl.ee      = ee_bit | force_q;
        ctl.ce      = ce_bit;
        ctl.hv      = hv_mode;
        ctl.ext_sel = part_ext_sel;
        ctl.hdec_en = part_hdec_en;
        ctl.has_hv  = hv_present;
    end

    irqarb_pend u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_pulse(src_set),
        .ext_lvl  (ext_lvl),
        .crit_lvl (crit_lvl),
        .clr_mask (clr_mask),
        .pwr_save (pwr_save_enter),
        .dlv_any  (take_valid),
        .pend_q   (pend_q),
        .force_q  (force_q)
    );

    irqarb_gate u_gate (
        .pend(pend_q),
        .ctl (ctl),
        .elig(elig)
    );

    irqarb_pick u_pick (
        .req  (elig),
        .grant(take_onehot),
        .cause(take_cause),
        .any  (take_valid)
    );

    assign hard_req = |pend_q;
endmodule

// File: rtl/irqarb_chk.sv
// Property checker bound to the arbiter top.
module irqarb_chk
    import irqarb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_set,
    input logic            ext_lvl,
    input logic            pwr_save_enter,
    input logic            take_valid,
    input logic [CW-1:0]   take_cause,
    input logic [NSRC-1:0] take_onehot,
    input logic            hard_req,
    input logic [NSRC-1:0] pend_q
);
    p_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_onehot) && (take_valid == (take_onehot != '0)));

    p_rst_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src_set[S_RST] |=> take_valid && take_cause == CW'(S_RST));

    p_mck_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && take_cause == CW'(S_MCK) && !src_set[S_MCK]) |=> !pend_q[S_MCK]);

    p_hdec_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_save_enter |=> !pend_q[S_HDEC]);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && take_cause == CW'(S_WDT) && src_set[S_WDT]) |=> pend_q[S_WDT]);

    p_hardreq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        src_set[S_MCK] |=> hard_req);

    p_ext_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_lvl |=> pend_q[S_EXT]);
endmodule

bind irq_pend_arbiter irqarb_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_set       (src_set),
    .ext_lvl       (ext_lvl),
    .pwr_save_enter(pwr_save_enter),
    .take_valid    (take_valid),
    .take_cause    (take_cause),
    .take_onehot   (take_onehot),
    .hard_req      (hard_req),
    .pend_q        (pend_q)
);

// File: tb/tb_irq_pend_arbiter.sv
module tb_irq_pend_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] src_set = '0;
    logic        ext_lvl = 0, crit_lvl = 0, ee_bit = 0, ce_bit = 0, hv_mode = 0;
    logic        part_ext_sel = 0, part_hdec_en = 0, hv_present = 0;
    logic        dec_clear_cfg = 0, pwr_save_enter = 0;
    logic        take_valid;
    logic [3:0]  take_cause;
    logic [12:0] take_onehot;
    logic        hard_req;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench reference state
    logic [12:0] m_pend = '0;
    logic        m_force = 0;

    always #5 clk = ~clk;

    irq_pend_arbiter dut (.*);

    function automatic logic [12:0] f_elig(logic [12:0] p, logic ee, logic ce,
                                           logic hv, logic xs, logic hde, logic hhv);
        logic [12:0] e;
        e[0] = p[0];
        e[1] = p[1];
        e[2] = p[2] & hde & (ee | ~hv);
        e[3] = p[3] & (ee | (hhv & ~hv & ~xs));
        e[4] = p[4] & ce;
        for (int i = 5; i < 13; i++) e[i] = p[i] & ee;
        return e;
    endfunction

    function automatic int f_pick(logic [12:0] e);
        for (int i = 0; i < 13; i++) if (e[i]) return i;
        return -1;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs against the model, then advance the model and the clock
    task automatic step(string tag);
        logic [12:0] e, nxt;
        int w;
        logic [12:0] oh;
        #1;
        e  = f_elig(m_pend, ee_bit | m_force, ce_bit, hv_mode, part_ext_sel, part_hdec_en, hv_present);
        w  = f_pick(e);
        oh = (w >= 0) ? (13'd1 << w) : 13'd0;
        chk({tag, " valid"}, 32'(take_valid), 32'(w >= 0));
        if (w >= 0) chk({tag, " cause"}, 32'(take_cause), 32'(w));
        chk({tag, " onehot R13"}, 32'(take_onehot), 32'(oh));
        chk({tag, " hard_req R10"}, 32'(hard_req), 32'(m_pend != 0));
        nxt = m_pend;
        if (w >= 0 && w != 3 && w != 4 && (w != 9 || dec_clear_cfg)) nxt[w] = 1'b0;
        nxt = nxt | (src_set & 13'h1fe7);
        nxt[3] = ext_lvl;
        nxt[4] = crit_lvl;
        if (pwr_save_enter) nxt[2] = 1'b0;
        m_force = pwr_save_enter | (m_force & ~(w >= 0));
        m_pend = nxt;
        @(negedge clk);
    endtask

    task automatic idle();
        src_set = '0; pwr_save_enter = 0;
    endtask

    initial begin
        int r;
        r = $urandom(32'd20240517);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12: reset state
        step("R12");
        // R11: set bits 3 and 4 ignored
        src_set = 13'b0_0000_0001_1000; step("R11");
        idle(); step("R11");
        chk("R11 no pending", 32'(hard_req), 32'd0);
        // R1 and R6: several ee-gated sources, ee low then high
        src_set = 13'b1_0001_0010_0000; step("R6");
        idle(); step("R6"); step("R6");
        ee_bit = 1; step("R1"); step("R1"); step("R1"); step("R1");
        // R9: watchdog set again in its own delivery cycle
        src_set = 13'b0_0000_0010_0000; step("R9");
        step("R9");
        idle(); step("R9"); step("R9");
        // R7: decrementer sticky without clear config
        src_set = 13'b0_0010_0000_0000; step("R7");
        idle(); step("R7"); step("R7");
        dec_clear_cfg = 1; step("R7"); step("R7");
        // R2: reset and machine check ignore enables
        ee_bit = 0; ce_bit = 0;
        src_set = 13'b0_0000_0000_0011; step("R2");
        idle(); step("R2"); step("R2"); step("R2");
        // R3: hypervisor decrementer gating
        src_set = 13'b0_0000_0000_0100; hv_mode = 1; part_hdec_en = 1; step("R3");
        idle(); step("R3");
        hv_mode = 0; step("R3"); step("R3");
        // R4: external bypass in guest state
        ext_lvl = 1; hv_present = 1; part_ext_sel = 0; step("R4"); step("R4"); step("R4");
        part_ext_sel = 1; step("R4");
        ext_lvl = 0; step("R4"); step("R4");
        // R5: critical external gated by ce
        crit_lvl = 1; step("R5"); step("R5");
        ce_bit = 1; step("R5");
        crit_lvl = 0; step("R5"); step("R5");
        ce_bit = 0;
        // R8: power save drops hdec, forces enable until next delivery
        src_set = 13'b0_0000_0000_0100; step("R8");
        src_set = 13'b1_0000_0000_0100; pwr_save_enter = 1; step("R8");
        idle(); step("R8"); step("R8"); step("R8");
        // random phase
        for (int k = 0; k < 3000; k++) begin
            for (int b = 0; b < 13; b++) src_set[b] = (($urandom % 8) == 0);
            if ($urandom % 4 != 0) src_set[0] = 0;
            if ($urandom % 4 != 0) src_set[1] = 0;
            ext_lvl = ($urandom % 4 == 0);
            crit_lvl = ($urandom % 4 == 0);
            ee_bit = ($urandom % 3 == 0);
            ce_bit = $urandom % 2;
            hv_mode = $urandom % 2;
            part_ext_sel = $urandom % 2;
            part_hdec_en = $urandom % 2;
            hv_present = $urandom % 2;
            dec_clear_cfg = $urandom % 2;
            pwr_save_enter = ($urandom % 16 == 0);
            step("R1 random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule